// File: doc/BRIEF.md
# Sub-word writable register file

This block is a bank of sixteen 64-bit general-purpose registers. It has one combinational read port and one clocked write port. Each port selects a register with a 4-bit index and an access width with a 2-bit size code. The four widths are 8, 16, 32 and 64 bits.

A read returns the low-order bits of the selected register for the chosen width. The bits of the 64-bit output above that width are zero.

Writes follow the integer rules of a 64-bit processor:
- A byte or halfword write replaces only its own low bits and keeps every higher bit of the register.
- A 32-bit write stores its value in the low half of the register and clears the high half.
- A 64-bit write replaces the whole register.

The block is intended to sit between an instruction decoder, which supplies the operand index and width, and an execution unit, which consumes and produces operand values.

Top module: `gprf_top`

## Requirements
- R1: The file holds 16 registers of 64 bits, selected by an index from 0 to 15. A write to one register leaves every other register unchanged.
- R2: The size code means 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 = 32 bits and 2'b11 = 64 bits, on both ports.
- R3: A read of width w returns bits w-1..0 of the selected register on `rd_data[w-1:0]`. Bits 63..w of `rd_data` are zero.
- R4: A 32-bit write stores `wr_data[31:0]` into bits 31..0 and forces bits 63..32 of the register to zero.
- R5: An 8-bit or 16-bit write replaces only bits w-1..0 with `wr_data[w-1:0]` and leaves bits 63..w of the register unchanged.
- R6: A 64-bit write replaces all 64 bits of the register with `wr_data`.
- R7: A write takes effect on the rising clock edge only when `wr_en` is 1. With `wr_en` at 0, no register changes, whatever the other write inputs carry.
- R8: The read port is combinational. A read of the register being written in the same cycle returns its value from before the write.
- R9: When `rst` is 1 at a rising edge, all 16 registers become zero. This reset overrides a write requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset of all registers |
| rd_idx | input | 4 | Register selected for reading |
| rd_size | input | 2 | Read width code |
| rd_data | output | 64 | Read value, zero above the access width |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | 4 | Register selected for writing |
| wr_size | input | 2 | Write width code |
| wr_data | input | 64 | Write value; only the bits of the access width are used |

## Verification
A read result is due in the same cycle as its index and size. The bench changes those inputs 4 ns before the next rising edge and samples `rd_data` 1 ns after the change, with no clock edge in between. A write, or a reset, is visible only after the rising edge that follows its request. The bench therefore drives write inputs at a falling edge and reads the register back after the next falling edge. It also reads the target register inside the write cycle itself, to confirm that the value from before the write is still returned there.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

    localparam int REG_W     = 64;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = REG_W / LANE_W;
    localparam int NUM_REGS  = 16;
    localparam int IDX_W     = $clog2(NUM_REGS);

    typedef enum logic [1:0] {
        SZ_B8  = 2'b00,
        SZ_B16 = 2'b01,
        SZ_B32 = 2'b10,
        SZ_B64 = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic               en;
        logic [IDX_W-1:0]   idx;
        acc_size_e          size;
        logic [REG_W-1:0]   data;
    } wr_req_t;

    typedef struct packed {
        logic [NUM_LANES-1:0] lane_en;
        logic [REG_W-1:0]     data;
    } lane_wr_t;

    // Number of byte lanes that carry operand data for a given width
    function automatic int size_lanes(acc_size_e s);
        return 1 << int'(s);
    endfunction

    // Lanes that belong to the operand
    function automatic logic [NUM_LANES-1:0] live_lanes(acc_size_e s);
        logic [NUM_LANES-1:0] m;
        for (int l = 0; l < NUM_LANES; l++) begin
            m[l] = (l < size_lanes(s));
        end
        return m;
    endfunction

    // Lanes a write modifies: a 32-bit write also clears the high lanes
    function automatic logic [NUM_LANES-1:0] touched_lanes(acc_size_e s);
        if (s == SZ_B32) begin
            return '1;
        end
        return live_lanes(s);
    endfunction

endpackage

// File: rtl/gprf_wr_shape.sv
module gprf_wr_shape
    import gprf_pkg::*;
(
    input  wr_req_t  req,
    output lane_wr_t lanes
);

    logic [NUM_LANES-1:0] live;

    assign live          = live_lanes(req.size);
    assign lanes.lane_en = req.en ? touched_lanes(req.size) : '0;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lanes.data[l*LANE_W +: LANE_W] =
            live[l] ? req.data[l*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/gprf_slot.sv
module gprf_slot
    import gprf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  lane_wr_t         wr,
    output logic [REG_W-1:0] q
);

    logic [LANE_W-1:0] lane_q [NUM_LANES];

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[l] <= '0;
            end else if (sel && wr.lane_en[l]) begin
                lane_q[l] <= wr.data[l*LANE_W +: LANE_W];
            end
        end
        assign q[l*LANE_W +: LANE_W] = lane_q[l];
    end

endmodule

// File: rtl/gprf_rd_trim.sv
module gprf_rd_trim
    import gprf_pkg::*;
(
    input  logic [REG_W-1:0] full,
    input  acc_size_e        size,
    output logic [REG_W-1:0] trimmed
);

    logic [NUM_LANES-1:0] live;

    assign live = live_lanes(size);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign trimmed[l*LANE_W +: LANE_W] =
            live[l] ? full[l*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/gprf_top.sv
module gprf_top
    import gprf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [1:0]          rd_size,
    output logic [REG_W-1:0]    rd_data,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [1:0]          wr_size,
    input  logic [REG_W-1:0]    wr_data
);

    wr_req_t          wr_req;
    lane_wr_t         wr_lanes;
    logic [REG_W-1:0] regs_q [NUM_REGS];
    logic [REG_W-1:0] rd_full;

    assign wr_req.en   = wr_en;
    assign wr_req.idx  = wr_idx;
    assign wr_req.size = acc_size_e'(wr_size);
    assign wr_req.data = wr_data;

    gprf_wr_shape u_shape (
        .req   (wr_req),
        .lanes (wr_lanes)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic sel;
        assign sel = wr_req.en && (wr_req.idx == IDX_W'(i));
        gprf_slot u_slot (
            .clk (clk),
            .rst (rst),
            .sel (sel),
            .wr  (wr_lanes),
            .q   (regs_q[i])
        );
    end

    assign rd_full = regs_q[rd_idx];

    gprf_rd_trim u_trim (
        .full    (rd_full),
        .size    (acc_size_e'(rd_size)),
        .trimmed (rd_data)
    );

endmodule

// File: rtl/gprf_chk.sv
module gprf_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  rd_idx,
    input logic [1:0]  rd_size,
    input logic [63:0] rd_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [1:0]  wr_size,
    input logic [63:0] wr_data
);

    p_rst_clears_r9: assert property (@(posedge clk)
        rst |=> (rd_data == 64'h0));

    p_rd_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_size != 2'b11) |-> (rd_data[63:32] == 32'h0));

    p_rd_byte_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_size == 2'b00) |-> (rd_data[63:8] == 56'h0));

    p_wr32_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b10) |=>
            (!(rd_idx == $past(wr_idx) && rd_size == 2'b11) ||
             (rd_data == {32'h0, $past(wr_data[31:0])})));

    p_sub_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_size[1] && rd_idx == wr_idx && rd_size == 2'b11) |=>
            (!(rd_idx == $past(rd_idx) && rd_size == 2'b11) ||
             ((rd_data[63:16] == $past(rd_data[63:16])) &&
              (rd_data[7:0] == $past(wr_data[7:0])))));

    p_wr64_full_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b11) |=>
            (!(rd_idx == $past(wr_idx) && rd_size == 2'b11) ||
             (rd_data == $past(wr_data))));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=>
            (!($stable(rd_idx) && $stable(rd_size)) || $stable(rd_data)));

endmodule

bind gprf_top gprf_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx),
    .rd_size (rd_size),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_size (wr_size),
    .wr_data (wr_data)
);

// File: tb/gprf_top_tb.sv
module gprf_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_idx = '0;
    logic [1:0]  rd_size = '0;
    logic [63:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_size = '0;
    logic [63:0] wr_data = '0;

    int total = 0;
    int bad   = 0;
    logic [63:0] mdl [16];

    always #4 clk = ~clk;

    gprf_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_size (rd_size),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_size (wr_size),
        .wr_data (wr_data)
    );

    function automatic logic [63:0] exp_write(logic [63:0] old, logic [63:0] d, logic [1:0] sz);
        case (sz)
            2'b00:   return {old[63:8], d[7:0]};
            2'b01:   return {old[63:16], d[15:0]};
            2'b10:   return {32'h0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [63:0] exp_read(logic [63:0] v, logic [1:0] sz);
        if (sz == 2'b11) return v;
        return v & ((64'h1 << (8 << sz)) - 64'h1);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Combinational read: change inputs away from the edge and sample 1 ns later
    task automatic rd_check(string req, int idx, logic [1:0] sz);
        rd_idx  = 4'(idx);
        rd_size = sz;
        #1;
        check(req, rd_data, exp_read(mdl[idx], sz));
    endtask

    task automatic do_write(int idx, logic [1:0] sz, logic [63:0] d, logic en);
        @(negedge clk);
        wr_en   = en;
        wr_idx  = 4'(idx);
        wr_size = sz;
        wr_data = d;
        @(negedge clk);
        if (en && !rst) mdl[idx] = exp_write(mdl[idx], d, sz);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state, every register and width
        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 4; s++) rd_check("R9 reset", i, 2'(s));
        end

        // R1 R2 R3 R4 R5 R6: sweep every register and write width
        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 4; s++) begin
                logic [63:0] pre;
                logic [63:0] dat;
                pre = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(i) * 64'h0101_0101_0101_0101);
                dat = 64'h1122_3344_5566_7788 + (64'(i * 4 + s) * 64'h0001_0203_0405_0607);
                do_write(i, 2'b11, pre, 1'b1);
                rd_check("R6 full write", i, 2'b11);
                do_write(i, 2'(s), dat, 1'b1);
                for (int r = 0; r < 4; r++) begin
                    case (s)
                        0, 1:    rd_check("R5 sub-word keeps upper bits", i, 2'(r));
                        2:       rd_check("R4 32-bit clears upper half", i, 2'(r));
                        default: rd_check("R3 R6 read width after full write", i, 2'(r));
                    endcase
                end
            end
        end

        // R1: isolation, all registers against the model
        for (int i = 0; i < 16; i++) rd_check("R1 isolation", i, 2'b11);

        // R7: disabled write has no effect
        do_write(7, 2'b11, 64'hDEAD_BEEF_CAFE_F00D, 1'b0);
        rd_check("R7 write enable low", 7, 2'b11);
        do_write(7, 2'b00, 64'hFF, 1'b0);
        rd_check("R7 write enable low byte", 7, 2'b00);

        // R8: read during write returns old value, then new value
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = 4'd5;
        wr_size = 2'b11;
        wr_data = 64'h0123_4567_89AB_CDEF;
        rd_check("R8 read during write old value", 5, 2'b11);
        @(negedge clk);
        wr_en = 1'b0;
        mdl[5] = 64'h0123_4567_89AB_CDEF;
        rd_check("R8 value after edge", 5, 2'b11);

        // R9: reset overrides a concurrent write
        @(negedge clk);
        rst     = 1'b1;
        wr_en   = 1'b1;
        wr_idx  = 4'd3;
        wr_size = 2'b11;
        wr_data = 64'h5555_AAAA_5555_AAAA;
        @(negedge clk);
        rst   = 1'b0;
        wr_en = 1'b0;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        for (int i = 0; i < 16; i++) rd_check("R9 reset over write", i, 2'b11);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule